// File: doc/BRIEF.md
# Operand-Isolated Multiplier Datapath

This block pairs a purely combinational unsigned multiplier with a 2:1 output selector. The select input decides whether the product or a pass-through alternate word reaches the output. When the alternate word is chosen, the product cannot be seen, so the block isolates the multiplier's operands. The multiplier array then stops switching, and the dynamic power it would have burned on an unseen result is saved.

The isolation style is fixed when the block is built, and one parameter picks it. Forcing the operands to zero suits operand bits that are mostly low. Forcing them to ones suits operand bits that are mostly high. Holding them in transparent latches freezes the array even across idle gaps one cycle long, at the price of the latches' own power. The select input drives the isolation directly.

An optional register can capture the selected result. A switching-activity counter totals the bit changes that reach the multiplier inputs, so that the styles can be compared under the same select pattern.

Top module: `opiso_mul_mux`

## Requirements
- R1: With the output register disabled and the select high, `res_o` equals the unsigned 2*WIDTH-bit product of `opa_i` and `opb_i` within the same cycle, in every isolation style.
- R2: With the select low, the selected result is `alt_i`, whatever the operands are.
- R3: With the output register enabled, `res_o` takes the value chosen under R1/R2 at the next rising clock edge. A synchronous reset drives `res_o` to zero.
- R4: In zero-forcing style (STYLE = ISO_AND), the operands seen by the multiplier are all zeros whenever the select is low.
- R5: In ones-forcing style (STYLE = ISO_OR), the operands seen by the multiplier are all ones whenever the select is low.
- R6: In latch style (STYLE = ISO_LATCH), the multiplier operands keep the last values present while the select was high. No multiplier input bit changes during a low-select period of any length, including a single cycle.
- R7: `toggles_o` is zero during reset. At each rising edge after reset, it grows by the number of multiplier-input bits, across both operands, that differ from their values at the previous edge.
- R8: All-ones operands give the exact product 2^(2W) - 2^(W+1) + 1, with no truncation (0xFFFE0001 for W = 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the activity counter |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | WIDTH | First multiplier operand |
| opb_i | input | WIDTH | Second multiplier operand |
| alt_i | input | 2*WIDTH | Alternate word, passed through when the select is low |
| sel_prod_i | input | 1 | 1 selects the product; 0 selects `alt_i` and isolates the operands |
| res_o | output | 2*WIDTH | Selected result, registered when OUT_REG = 1 |
| toggles_o | output | CNT_W | Running count of multiplier-input bit changes |

## Verification
The bench drives three builds with the same stimulus, one for each isolation style, and predicts every activity count from the requirements. A single-cycle dip in the select is the sharpest case. The forcing styles must record a burst of changes on entry to isolation and another on exit, while the latch style records none in between. An inverted enable, or a latch that stays open, would show up as a wrong count. Multi-cycle gaps with changing operands catch a forcing style that lets operand bits leak through. All-ones operands catch a product width that is truncated. The registered build catches a result that is taken one cycle early or late, or that does not clear on reset.

// File: rtl/opiso_pkg.sv
`timescale 1ns/1ps
package opiso_pkg;

    // Which way operands are isolated while the product is unused.
    typedef enum logic [1:0] {
        ISO_AND   = 2'd0,
        ISO_OR    = 2'd1,
        ISO_LATCH = 2'd2
    } iso_style_e;

    localparam int DEF_WIDTH = 16;
    localparam int DEF_CNT_W = 32;

    // Bits of a full-width product for a given operand width.
    function automatic int prod_width(input int w);
        return 2 * w;
    endfunction

endpackage

// File: rtl/opiso_isolate.sv
`timescale 1ns/1ps
module opiso_isolate
    import opiso_pkg::*;
#(
    parameter int         WIDTH = DEF_WIDTH,
    parameter iso_style_e STYLE = ISO_AND
) (
    input  logic             obs_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STYLE == ISO_AND) begin : g_and
            // Idle operands sit at zero.
            assign q_o = d_i & {WIDTH{obs_i}};
        end else if (STYLE == ISO_OR) begin : g_or
            // Idle operands sit at all ones.
            assign q_o = d_i | {WIDTH{~obs_i}};
        end else begin : g_lat
            logic [WIDTH-1:0] hold_q;
            // Open while the product is used, closed otherwise.
            always_latch begin
                if (obs_i) hold_q <= d_i;
            end
            assign q_o = hold_q;
        end
    endgenerate

endmodule

// File: rtl/opiso_mult.sv
`timescale 1ns/1ps
module opiso_mult
    import opiso_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0]                  a_i,
    input  logic [WIDTH-1:0]                  b_i,
    output logic [prod_width(WIDTH)-1:0]      p_o
);

    localparam int PW = prod_width(WIDTH);

    // Flop-free unsigned array multiplier.
    assign p_o = PW'(a_i) * PW'(b_i);

endmodule

// File: rtl/opiso_toggle_cnt.sv
`timescale 1ns/1ps
module opiso_toggle_cnt #(
    parameter int BUS_W = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [BUS_W-1:0] snap_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        snap_q <= bus_i;
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CNT_W'($countones(bus_i ^ snap_q));
    end

    assign cnt_o = cnt_q;

    // R7: the activity total never goes backwards.
    a_r7_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/opiso_mul_mux.sv
`timescale 1ns/1ps
module opiso_mul_mux
    import opiso_pkg::*;
#(
    parameter int         WIDTH   = DEF_WIDTH,
    parameter iso_style_e STYLE   = ISO_AND,
    parameter bit         OUT_REG = 1'b0,
    parameter int         CNT_W   = DEF_CNT_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [WIDTH-1:0]          opa_i,
    input  logic [WIDTH-1:0]          opb_i,
    input  logic [2*WIDTH-1:0]        alt_i,
    input  logic                      sel_prod_i,
    output logic [2*WIDTH-1:0]        res_o,
    output logic [CNT_W-1:0]          toggles_o
);

    localparam int PW = prod_width(WIDTH);

    logic [WIDTH-1:0] iso_a, iso_b;
    logic [PW-1:0]    prod_w;
    logic [PW-1:0]    pick_w;

    opiso_isolate #(.WIDTH(WIDTH), .STYLE(STYLE)) u_iso_a (
        .obs_i (sel_prod_i),
        .d_i   (opa_i),
        .q_o   (iso_a)
    );

    opiso_isolate #(.WIDTH(WIDTH), .STYLE(STYLE)) u_iso_b (
        .obs_i (sel_prod_i),
        .d_i   (opb_i),
        .q_o   (iso_b)
    );

    opiso_mult #(.WIDTH(WIDTH)) u_mult (
        .a_i (iso_a),
        .b_i (iso_b),
        .p_o (prod_w)
    );

    assign pick_w = sel_prod_i ? prod_w : alt_i;

    opiso_toggle_cnt #(.BUS_W(2*WIDTH), .CNT_W(CNT_W)) u_act (
        .clk   (clk),
        .rst   (rst),
        .bus_i ({iso_a, iso_b}),
        .cnt_o (toggles_o)
    );

    // Product of the raw ports, used only by the checks below.
    logic [PW-1:0] port_prod;
    assign port_prod = PW'(opa_i) * PW'(opb_i);

    generate
        if (OUT_REG) begin : g_reg
            logic [PW-1:0] res_q;
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= pick_w;
            end
            assign res_o = res_q;

            // R3: the registered result is one cycle behind the ports.
            a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> res_o == ($past(sel_prod_i) ? $past(port_prod) : $past(alt_i)));
        end else begin : g_comb
            assign res_o = pick_w;

            // R1: a selected product matches the raw operands.
            a_r1_product: assert property (@(posedge clk) disable iff (rst)
                sel_prod_i |-> res_o == port_prod);

            // R2: the alternate word passes through unchanged.
            a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
                !sel_prod_i |-> res_o == alt_i);
        end
    endgenerate

    // R6 (and R4/R5): the multiplier inputs stay still across back-to-back idle samples.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!sel_prod_i && !$past(sel_prod_i)) |-> ($stable(iso_a) && $stable(iso_b)));

endmodule

// File: tb/test_opiso_mul_mux.sv
`timescale 1ns/1ps
module test_opiso_mul_mux;
    import opiso_pkg::*;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  opa = '0, opb = '0;
    logic [2*W-1:0] alt = '0;
    logic          sel = 1'b1;

    logic [2*W-1:0] res_and, res_or, res_lat;
    logic [31:0]    cnt_and, cnt_or, cnt_lat;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Reference state built from the requirements.
    logic [2*W-1:0] g_and, g_or, g_lat, p_and, p_or, p_lat, h_lat;
    logic [31:0]    e_and, e_or, e_lat;

    always #10 clk = ~clk;   // 50 MHz

    opiso_mul_mux #(.WIDTH(W), .STYLE(ISO_AND), .OUT_REG(1'b0)) i_opiso_mul_mux (
        .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .alt_i(alt),
        .sel_prod_i(sel), .res_o(res_and), .toggles_o(cnt_and));

    opiso_mul_mux #(.WIDTH(W), .STYLE(ISO_OR), .OUT_REG(1'b0)) i_opiso_mul_mux_or (
        .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .alt_i(alt),
        .sel_prod_i(sel), .res_o(res_or), .toggles_o(cnt_or));

    opiso_mul_mux #(.WIDTH(W), .STYLE(ISO_LATCH), .OUT_REG(1'b1)) i_opiso_mul_mux_lat (
        .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .alt_i(alt),
        .sel_prod_i(sel), .res_o(res_lat), .toggles_o(cnt_lat));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus with every check for that cycle.
    task automatic cyc(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2*W-1:0] al, input logic s);
        logic [2*W-1:0] want;
        @(negedge clk);
        opa = a; opb = b; alt = al; sel = s;
        #5;
        want = s ? ({16'b0, a} * {16'b0, b}) : al;
        check(s ? "R1 and-style" : "R2 and-style", 64'(res_and), 64'(want));
        check(s ? "R1 or-style"  : "R2 or-style",  64'(res_or),  64'(want));
        g_and = s ? {a, b} : '0;
        g_or  = s ? {a, b} : '1;
        if (s) h_lat = {a, b};
        g_lat = h_lat;
        @(posedge clk);
        #1;
        e_and += 32'($countones(g_and ^ p_and)); p_and = g_and;
        e_or  += 32'($countones(g_or  ^ p_or));  p_or  = g_or;
        e_lat += 32'($countones(g_lat ^ p_lat)); p_lat = g_lat;
        check("R4 R7 and-style toggles", 64'(cnt_and), 64'(e_and));
        check("R5 R7 or-style toggles",  64'(cnt_or),  64'(e_or));
        check("R6 R7 latch toggles",     64'(cnt_lat), 64'(e_lat));
        check("R3 registered result",    64'(res_lat), 64'(want));
    endtask

    task automatic t_reset();
        rst = 1'b1; sel = 1'b1; opa = '0; opb = '0; alt = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R3 reset clears result", 64'(res_lat), 64'd0);
        check("R7 reset clears count",  64'(cnt_and), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        g_and = '0; g_or = '0; g_lat = '0; h_lat = '0;
        p_and = '0; p_or = '0; p_lat = '0;
        e_and = '0; e_or = '0; e_lat = '0;
        #1;
        check("R7 count zero after release", 64'(cnt_lat), 64'd0);
    endtask

    task automatic t_product();
        for (int i = 0; i < 20; i++)
            cyc(W'($urandom), W'($urandom), 32'($urandom), 1'b1);
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 10; i++)
            cyc(W'($urandom), W'($urandom), 32'($urandom), 1'b0);
    endtask

    task automatic t_single_gaps();
        for (int i = 0; i < 24; i++)
            cyc(W'($urandom), W'($urandom), 32'($urandom), (i % 2) == 0);
    endtask

    task automatic t_long_gaps();
        for (int r = 0; r < 4; r++)
            for (int k = 0; k < 6; k++)
                cyc(W'($urandom), W'($urandom), 32'($urandom), k == 0);
    endtask

    task automatic t_extremes();
        cyc('1, '1, '0, 1'b1);
        check("R8 all-ones product", 64'(res_and), 64'h0000_0000_FFFE_0001);
        cyc('0, '1, '1, 1'b1);
        cyc('1, '1, '1, 1'b0);
        cyc('1, '0, '0, 1'b1);
        cyc(16'h8000, 16'h8000, '0, 1'b1);
        check("R8 high-bit product", 64'(res_or), 64'h0000_0000_4000_0000);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_product();
        t_alternate();
        t_single_gaps();
        t_long_gaps();
        t_extremes();
        t_single_gaps();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule